// File: doc/BRIEF.md
# Isolated-Side Sample Sequencer

This block is the digital controller on the isolated half of a self-powered, sampled comparator. The isolated half has no steady supply of its own. It stores charge on a capacitor and can afford a measurement only now and then. The sequencer watches two flags. The first says the stored supply is high enough to run a measurement. The second says the far side has stopped sending power and is now listening for a reply. When both flags are high, the sequencer runs one timed sample. It turns on the reference output for a fixed window. It enables the comparator only during the closing part of that window. It captures the comparator bit at the final cycle of the window and sends the bit back over a redundant true/complement pair.

The block also drives a three-state result pin, given here as a data bit and an output enable. The pin is driven only while the reference is on. It shows the result of the previous comparison, so circuits on the isolated side can use it for hysteresis. All timing is in clock cycles, derived from a cycles-per-microsecond parameter. The window lengths can therefore be checked exactly at any clock rate.

Top module: `iso_sample_seq`

## Requirements
- R1: A sample starts only from the idle state, and only in a cycle where `listen` and `supply_ok` are both high. If `supply_ok` is low, `ref_en` stays low however long `listen` is high.
- R2: Once a sample starts, `ref_en` is high for exactly REF_US*CYC_PER_US consecutive cycles (108 µs).
- R3: `cmp_en` is high only inside the reference window. It is high for exactly the final CMP_US*CYC_PER_US cycles of that window (10 µs), including the window's last cycle.
- R4: `res_oe` is high exactly in the cycles where `ref_en` is high, and low at all other times.
- R5: While `res_oe` is high, `res_q` holds the result of the previous completed comparison. It holds 0 if no comparison has completed since reset.
- R6: The captured result is the value of `cmp_in` in the last cycle of the reference window. `cap_stb` is high for exactly the one cycle after that window ends.
- R7: The result is sent as a 3-cycle frame that starts in the cycle after the window ends. In each frame cycle `tx_p` equals the result and `tx_n` equals its inverse. Outside a frame both lines are 0.
- R8: If `listen` falls during a sample, the sample still runs to completion and its frame is still sent.
- R9: Only one sample runs per listen window. After a frame, no new sample starts until `listen` has been seen low.
- R10: The asynchronous active-low reset clears the stored result to 0 and forces `ref_en`, `cmp_en`, `cap_stb`, `tx_p`, `tx_n` and `res_oe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Isolated-side clock |
| rst_n | input | 1 | Power-on reset, active low; asserts asynchronously, releases synchronously |
| supply_ok | input | 1 | Stored supply is at or above the run threshold |
| listen | input | 1 | Far side is in its listen period |
| cmp_in | input | 1 | Comparator decision bit |
| ref_en | output | 1 | Reference output enable |
| cmp_en | output | 1 | Comparator enable, closing part of the window only |
| cap_stb | output | 1 | One-cycle pulse after the result is captured |
| tx_p | output | 1 | Result, true line of the return pair |
| tx_n | output | 1 | Result, complement line of the return pair |
| res_q | output | 1 | Previous result for the three-state pin |
| res_oe | output | 1 | Drive enable for the three-state pin |

## Verification
The bench changes `cmp_in` from the inverse of the wanted value to the wanted value only once `cmp_en` rises. A design that captured early, at the window's start, would therefore send the wrong bit. Window lengths are measured cycle by cycle, so a window that is off by one, or a comparator window that closes before the reference window, shows up as a wrong count. The bench drops `listen` in the middle of a sample, and also holds it high after a frame. A design that aborted the sample, or that started a second sample in the same listen window, would lose a frame or add an extra start. Finally, the bench resets after a sample whose result was 1 and checks that the next driven `res_q` is 0. A design that left the stored result alive across reset would fail that check.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WIN  = 2'd1,
    SEQ_SEND = 2'd2,
    SEQ_HOLD = 2'd3
  } seq_state_t;
endpackage

// File: rtl/iso_seq_rst_sync.sv
module iso_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/iso_seq_window.sv
module iso_seq_window #(
  parameter int REF_CYC = 432,
  parameter int CMP_CYC = 40,
  localparam int CW = $clog2(REF_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active,
  output logic cmp_win,
  output logic last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  assign cnt_en = load || act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      cnt_d = CW'(REF_CYC - 1);
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active  = act_q;
  assign cmp_win = act_q && (cnt_q < CW'(CMP_CYC));
  assign last    = act_q && (cnt_q == '0);

  // R2: the controller never reloads a window that is still running
  p_no_retrigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !act_q);
endmodule

// File: rtl/iso_seq_tx.sv
module iso_seq_tx #(
  parameter int FRAME_BITS = 3,
  localparam int FW = $clog2(FRAME_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bit_in,
  output logic tx_p,
  output logic tx_n,
  output logic done
);
  logic [FW-1:0] left_q, left_d;
  logic          busy_q, busy_d;
  logic          data_q, data_d;
  logic          step_en;

  assign step_en = start || busy_q;

  always_comb begin
    left_d = left_q;
    busy_d = busy_q;
    data_d = data_q;
    if (start) begin
      left_d = FW'(FRAME_BITS - 1);
      busy_d = 1'b1;
      data_d = bit_in;
    end else if (busy_q) begin
      if (left_q == '0) busy_d = 1'b0;
      else              left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy_q <= 1'b0;
      data_q <= 1'b0;
    end else if (step_en) begin
      left_q <= left_d;
      busy_q <= busy_d;
      data_q <= data_d;
    end
  end

  assign tx_p = busy_q && data_q;
  assign tx_n = busy_q && !data_q;
  assign done = busy_q && (left_q == '0);

  // R7: the two lines of the return pair are never high together
  p_tx_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_p && tx_n));
  // R7: a frame holds the same symbol from one cycle to the next
  p_frame_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(start)) |-> $stable(tx_p));
endmodule

// File: rtl/iso_seq_ctrl.sv
module iso_seq_ctrl
  import iso_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       listen,
  input  logic       supply_ok,
  input  logic       win_last,
  input  logic       tx_done,
  output logic       win_load,
  output logic       tx_start,
  output seq_state_t state
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d     = st_q;
    win_load = 1'b0;
    tx_start = 1'b0;
    unique case (st_q)
      SEQ_IDLE: if (listen && supply_ok) begin
        win_load = 1'b1;
        st_d     = SEQ_WIN;
      end
      SEQ_WIN: if (win_last) begin
        tx_start = 1'b1;
        st_d     = SEQ_SEND;
      end
      SEQ_SEND: if (tx_done) st_d = SEQ_HOLD;
      SEQ_HOLD: if (!listen) st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R8: a sample in progress is not abandoned when listen falls
  p_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_WIN && !win_last) |=> (st_q == SEQ_WIN));
endmodule

// File: rtl/iso_sample_seq.sv
module iso_sample_seq #(
  parameter int CYC_PER_US = 4,
  parameter int REF_US     = 108,
  parameter int CMP_US     = 10,
  parameter int FRAME_BITS = 3,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic listen,
  input  logic cmp_in,
  output logic ref_en,
  output logic cmp_en,
  output logic cap_stb,
  output logic tx_p,
  output logic tx_n,
  output logic res_q,
  output logic res_oe
);
  import iso_seq_pkg::*;

  localparam int REF_CYC = REF_US * CYC_PER_US;
  localparam int CMP_CYC = CMP_US * CYC_PER_US;

  logic       srst_n;
  logic       win_load, win_act, win_cmp, win_last;
  logic       tx_start, tx_done;
  logic       held_q, held_d;
  logic       stb_q;
  seq_state_t state;

  iso_seq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  iso_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(srst_n), .listen(listen), .supply_ok(supply_ok),
    .win_last(win_last), .tx_done(tx_done),
    .win_load(win_load), .tx_start(tx_start), .state(state)
  );

  iso_seq_window #(.REF_CYC(REF_CYC), .CMP_CYC(CMP_CYC)) u_win (
    .clk(clk), .rst_n(srst_n), .load(win_load),
    .active(win_act), .cmp_win(win_cmp), .last(win_last)
  );

  iso_seq_tx #(.FRAME_BITS(FRAME_BITS)) u_tx (
    .clk(clk), .rst_n(srst_n), .start(tx_start), .bit_in(cmp_in),
    .tx_p(tx_p), .tx_n(tx_n), .done(tx_done)
  );

  always_comb begin
    held_d = held_q;
    if (tx_start) held_d = cmp_in;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      held_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      stb_q  <= tx_start;
    end
  end

  assign ref_en  = win_act;
  assign cmp_en  = win_cmp;
  assign cap_stb = stb_q;
  assign res_oe  = win_act;
  assign res_q   = held_q;

  // R1: a window opens only after a cycle with both enabling flags high
  p_start_gate_r1: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(ref_en) |-> $past(listen && supply_ok));
  // R3: the comparator is still enabled in the closing cycle of the window
  p_cmp_tail_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(ref_en) |-> $past(cmp_en));
  // R5: the presented result never changes while it is driven
  p_q_stable_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (res_oe && $past(res_oe)) |-> $stable(res_q));
  // R6: the capture strobe follows the close of the window
  p_stb_after_r6: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(ref_en) |-> cap_stb);
  // R7: a frame begins together with the capture strobe
  p_frame_start_r7: assert property (@(posedge clk) disable iff (!srst_n)
    cap_stb |-> (tx_p || tx_n));
endmodule

// File: tb/tb_iso_sample_seq.sv
`timescale 1ns/1ps
module tb_iso_sample_seq;
  localparam int CYC_PER_US = 4;
  localparam int REF_CYC = 108 * CYC_PER_US;
  localparam int CMP_CYC = 10 * CYC_PER_US;

  logic clk = 1'b0;
  logic rst_n, supply_ok, listen, cmp_in;
  logic ref_en, cmp_en, cap_stb, tx_p, tx_n, res_q, res_oe;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int frames = 0;
  bit exp_q[$];

  always #2.5 clk = ~clk;

  iso_sample_seq #(.CYC_PER_US(CYC_PER_US)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .listen(listen),
    .cmp_in(cmp_in), .ref_en(ref_en), .cmp_en(cmp_en), .cap_stb(cap_stb),
    .tx_p(tx_p), .tx_n(tx_n), .res_q(res_q), .res_oe(res_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  int  ref_run = 0, cmp_run = 0, nbits = 0;
  bit  prev = 1'b0, cmp_last = 1'b0, oe_bad = 1'b0, q_bad = 1'b0;
  bit  fbit = 1'b0, fbad = 1'b0, was_ref = 1'b0, stb_pending = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev = 1'b0; ref_run = 0; cmp_run = 0; nbits = 0; was_ref = 1'b0;
      oe_bad = 1'b0; q_bad = 1'b0; stb_pending = 1'b0;
    end else begin
      if (res_oe != ref_en) oe_bad = 1'b1;
      if (cmp_en && !ref_en) cmp_run = cmp_run + 1000;
      if (ref_en) begin
        if (!was_ref) starts++;
        ref_run++;
        if (cmp_en) cmp_run++;
        cmp_last = cmp_en;
        if (res_q != prev) q_bad = 1'b1;
      end else if (was_ref) begin
        chk(ref_run == REF_CYC, "R2 window length", ref_run, REF_CYC);
        chk(cmp_run == CMP_CYC && cmp_last, "R3 comparator window", cmp_run, CMP_CYC);
        chk(!oe_bad, "R4 output enable tracks reference", oe_bad, 0);
        chk(!q_bad, "R5 previous result presented", q_bad, 0);
        chk(cap_stb, "R6 capture strobe", cap_stb, 1);
        ref_run = 0; cmp_run = 0; oe_bad = 1'b0; q_bad = 1'b0;
        stb_pending = 1'b1;
      end else if (stb_pending) begin
        chk(!cap_stb, "R6 strobe lasts one cycle", cap_stb, 0);
        stb_pending = 1'b0;
      end
      was_ref = ref_en;
      if (tx_p != tx_n) begin
        if (nbits == 0) fbit = tx_p;
        else if (tx_p != fbit) fbad = 1'b1;
        nbits++;
      end else begin
        if (tx_p) fbad = 1'b1;
        if (nbits > 0) begin
          bit e;
          chk(nbits == 3 && !fbad, "R7 frame shape", nbits, 3);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected frame", fbit, -1);
          end else begin
            e = exp_q.pop_front();
            chk(fbit == e, "R6 captured value", fbit, e);
          end
          prev = fbit; nbits = 0; fbad = 1'b0; frames++;
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; listen = 1'b0; supply_ok = 1'b0; cmp_in = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic run_sample(input bit v, input bit drop_mid, input string tag);
    int f0, s0;
    f0 = frames;
    supply_ok = 1'b1; cmp_in = ~v; listen = 1'b1;
    exp_q.push_back(v);
    do @(negedge clk); while (!ref_en);
    if (drop_mid) listen = 1'b0;
    do @(negedge clk); while (!cmp_en);
    cmp_in = v;
    do @(negedge clk); while (frames == f0);
    chk(frames == f0 + 1, tag, frames - f0, 1);
    if (!drop_mid) begin
      s0 = starts;
      wait_cyc(30);
      chk(starts == s0, "R9 no second sample while listen stays high", starts - s0, 0);
      listen = 1'b0;
    end
    wait_cyc(3);
  endtask

  initial begin : watchdog
    #(5.0 * 60000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    do_reset();
    // R10: reset state
    chk({ref_en, cmp_en, cap_stb, tx_p, tx_n, res_oe} == 6'b0, "R10 reset outputs",
        {ref_en, cmp_en, cap_stb, tx_p, tx_n, res_oe}, 0);
    // R1: listen without supply
    s0 = starts;
    listen = 1'b1; supply_ok = 1'b0;
    wait_cyc(50);
    chk(starts == s0 && !ref_en, "R1 no start without supply", starts - s0, 0);
    listen = 1'b0; supply_ok = 1'b1;
    wait_cyc(20);
    chk(starts == s0, "R1 no start without listen", starts - s0, 0);
    run_sample(1'b1, 1'b0, "R7 frame after sample one");
    run_sample(1'b0, 1'b0, "R7 frame after sample zero");
    run_sample(1'b1, 1'b1, "R8 listen drop mid-sample");
    run_sample(1'b1, 1'b0, "R5 repeat one");
    // R10: reset clears stored one; next window must present 0
    do_reset();
    chk(res_q == 1'b0, "R10 stored result cleared", res_q, 0);
    run_sample(1'b0, 1'b0, "R10 sample after reset");
    chk(exp_q.size() == 0, "R6 all frames received", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule